// File: doc/BRIEF.md
# Deep-Stop Standby Power Controller

This block sequences a small microcontroller into and out of its deepest low-power mode. Software first arms the mode through a mode-select register and then writes a stop request bit in a control register. From the next clock edge the CPU clock enable is low and the main oscillator is told to halt. The subclock domain and its peripherals are outside this block and keep running.

A wake event starts the return to normal operation. It can be the non-maskable interrupt, any unmasked line among seven external interrupt pins, or any unmasked line from the peripherals that run during stop. The main oscillator is restarted at once, and a programmable stabilization count runs down while the CPU clock stays gated. When the count expires the CPU clock comes back. In the same cycle the block reports whether the CPU must branch to the interrupt handler or continue at the next instruction with the request left pending. That decision uses the priority of the request, the priority of any handler in service and the CPU interrupt-enable state, all captured at the wake edge. An asynchronous active-low reset returns everything to the running state at once and produces no resume report.

Top module: `stop_power_ctrl`

## Requirements
- R1: After reset, cpu_clk_en=1, osc_stop=0, in_stop=0, in_wait=0, stop_flag=0, resume=0, take_irq=0 and hold_pending=0. The stabilization reload register resets to STAB_RESET (16).
- R2: A write of reg_wdata[0]=1 to address 1 (control), while the run state is active and bit 0 of address 0 (mode select) holds 1, makes the block enter stop from the next edge: in_stop=1, stop_flag=1, cpu_clk_en=0, osc_stop=1.
- R3: A stop request written while mode select is 0 has no effect: the block stays in run and stop_flag stays 0.
- R4: While in stop, interrupt lines whose mask bit is 1 (ext_mask or per_mask) do not wake the block, and it stays in stop.
- R5: While in stop, nmi_req=1, or any ext_irq or per_irq bit whose mask bit is 0, moves the block at that edge to the wait state: in_wait=1, in_stop=0, osc_stop=0, cpu_clk_en=0.
- R6: With N written to address 2 (the stabilization reload), resume pulses high in the (N+1)-th cycle after the wake edge, and cpu_clk_en returns to 1 in that same cycle. N=0 gives the shortest wait of one cycle.
- R7: A wake that includes nmi_req reports take_irq=1, whatever the other inputs are.
- R8: A maskable wake with in_service=1 and irq_prio >= svc_prio (a larger number means a lower priority) reports take_irq=0 and hold_pending=1.
- R9: A maskable wake that outranks the request in service, or that comes with in_service=0, reports take_irq=int_en and hold_pending=!int_en.
- R10: Reset asserted during stop or wait returns the block to the R1 state without waiting for a clock, and no resume pulse follows.
- R11: stop_flag clears at the wake edge. After resume the block stays in run until a new stop request is written.
- R12: resume lasts exactly one cycle. take_irq and hold_pending are 0 whenever resume is 0, and exactly one of them is 1 when resume is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode select, 1 control, 2 stabilization reload |
| reg_wdata | input | DATA_W | Write data |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_irq | input | N_EXT | External interrupt pin requests |
| ext_mask | input | N_EXT | External interrupt masks, 1 = masked |
| per_irq | input | N_PER | Stop-capable peripheral interrupt requests |
| per_mask | input | N_PER | Peripheral interrupt masks, 1 = masked |
| in_service | input | 1 | Stop was entered from inside an interrupt handler |
| svc_prio | input | PRIO_W | Priority of the handler in service (0 = highest) |
| irq_prio | input | PRIO_W | Priority of the highest pending maskable request |
| int_en | input | 1 | CPU interrupt-enable state |
| cpu_clk_en | output | 1 | Main clock enable to the CPU and peripherals |
| osc_stop | output | 1 | Main oscillator halt request |
| in_stop | output | 1 | Block is in stop |
| in_wait | output | 1 | Stabilization interval in progress |
| stop_flag | output | 1 | Current value of the stop request bit |
| resume | output | 1 | One-cycle pulse on the return to run |
| take_irq | output | 1 | With resume: branch to the handler |
| hold_pending | output | 1 | With resume: next instruction, request left pending |

## Verification
The bench sweeps the stabilization count across zero and larger values, and checks the exact resume cycle each time. An off-by-one in the counter would show up as a pulse one cycle early or late. Priority ties between the waking request and the handler in service are driven on purpose. A design that treated equal priority as outranking would acknowledge a request that must stay pending. The bench also wakes with NMI and a maskable line together, and in the disabled-interrupt state, to catch a design that lets the maskable path decide the outcome. Reset is applied during both stop and wait to expose a design that still emits a stale resume report.

// File: rtl/stop_pwr_pkg.sv
package stop_pwr_pkg;
  parameter int PRIO_W = 3;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_STOP = 2'd1,
    PS_WAIT = 2'd2
  } pwr_state_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAB = 2'd2;

  typedef struct packed {
    logic take;
    logic hold;
  } wake_class_t;

  // smaller number = more urgent
  function automatic logic prio_outranks(input logic [PRIO_W-1:0] req,
                                         input logic [PRIO_W-1:0] svc);
    return req < svc;
  endfunction

  function automatic wake_class_t classify_wake(input logic nmi,
                                                input logic in_svc,
                                                input logic outranks,
                                                input logic ie);
    wake_class_t c;
    c.take = nmi | (ie & (~in_svc | outranks));
    c.hold = ~c.take;
    return c;
  endfunction
endpackage

// File: rtl/stop_mode_regs.sv
module stop_mode_regs
  import stop_pwr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STAB_RESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              run_active,
  input  logic              clear_stop,
  output logic              stop_accept,
  output logic              stop_flag,
  output logic [DATA_W-1:0] stab_reload
);
  logic mode_sel;

  assign stop_accept = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0]
                       && mode_sel && run_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sel    <= 1'b0;
      stab_reload <= DATA_W'(STAB_RESET);
    end else if (reg_wr) begin
      if (reg_addr == ADDR_MODE) mode_sel <= reg_wdata[0];
      if (reg_addr == ADDR_STAB) stab_reload <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stop_flag <= 1'b0;
    else if (clear_stop)  stop_flag <= 1'b0;
    else if (stop_accept) stop_flag <= 1'b1;
  end
endmodule

// File: rtl/stop_wake_detect.sv
module stop_wake_detect
  import stop_pwr_pkg::*;
#(
  parameter int N_EXT = 7,
  parameter int N_PER = 4
) (
  input  logic              nmi_req,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_mask,
  input  logic [N_PER-1:0]  per_irq,
  input  logic [N_PER-1:0]  per_mask,
  input  logic              in_service,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic              int_en,
  output logic              wake,
  output wake_class_t       wake_cls
);
  logic [N_EXT-1:0] ext_live;
  logic [N_PER-1:0] per_live;
  logic             mask_wake;

  genvar gi;
  generate
    for (gi = 0; gi < N_EXT; gi++) begin : g_ext
      assign ext_live[gi] = ext_irq[gi] & ~ext_mask[gi];
    end
    for (gi = 0; gi < N_PER; gi++) begin : g_per
      assign per_live[gi] = per_irq[gi] & ~per_mask[gi];
    end
  endgenerate

  assign mask_wake = (|ext_live) | (|per_live);
  assign wake      = nmi_req | mask_wake;
  assign wake_cls  = classify_wake(nmi_req, in_service,
                                   prio_outranks(irq_prio, svc_prio), int_en);
endmodule

// File: rtl/stop_stab_counter.sv
module stop_stab_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = count_en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (count_en && cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_accept,
  input  logic        wake,
  input  wake_class_t wake_cls,
  input  logic        stab_done,
  output pwr_state_e  state,
  output logic        wake_evt,
  output logic        resume,
  output logic        take_irq,
  output logic        hold_pending
);
  wake_class_t cls_q;

  assign wake_evt = (state == PS_STOP) && wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= PS_RUN;
      cls_q        <= '0;
      resume       <= 1'b0;
      take_irq     <= 1'b0;
      hold_pending <= 1'b0;
    end else begin
      resume       <= 1'b0;
      take_irq     <= 1'b0;
      hold_pending <= 1'b0;
      unique case (state)
        PS_RUN:  if (stop_accept) state <= PS_STOP;
        PS_STOP: if (wake_evt) begin
          state <= PS_WAIT;
          cls_q <= wake_cls;
        end
        PS_WAIT: if (stab_done) begin
          state        <= PS_RUN;
          resume       <= 1'b1;
          take_irq     <= cls_q.take;
          hold_pending <= cls_q.hold;
        end
        default: state <= PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/stop_power_ctrl.sv
module stop_power_ctrl
  import stop_pwr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int N_EXT      = 7,
  parameter int N_PER      = 4,
  parameter int STAB_RESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              nmi_req,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_mask,
  input  logic [N_PER-1:0]  per_irq,
  input  logic [N_PER-1:0]  per_mask,
  input  logic              in_service,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic              int_en,
  output logic              cpu_clk_en,
  output logic              osc_stop,
  output logic              in_stop,
  output logic              in_wait,
  output logic              stop_flag,
  output logic              resume,
  output logic              take_irq,
  output logic              hold_pending
);
  pwr_state_e        state;
  logic              stop_accept;
  logic              wake;
  logic              wake_evt;
  logic              stab_done;
  wake_class_t       wake_cls;
  logic [DATA_W-1:0] stab_reload;

  stop_mode_regs #(.DATA_W(DATA_W), .STAB_RESET(STAB_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .run_active(state == PS_RUN),
    .clear_stop(wake_evt), .stop_accept(stop_accept),
    .stop_flag(stop_flag), .stab_reload(stab_reload)
  );

  stop_wake_detect #(.N_EXT(N_EXT), .N_PER(N_PER)) u_wake (
    .nmi_req(nmi_req), .ext_irq(ext_irq), .ext_mask(ext_mask),
    .per_irq(per_irq), .per_mask(per_mask), .in_service(in_service),
    .svc_prio(svc_prio), .irq_prio(irq_prio), .int_en(int_en),
    .wake(wake), .wake_cls(wake_cls)
  );

  stop_stab_counter #(.CNT_W(DATA_W)) u_stab (
    .clk(clk), .rst_n(rst_n), .load(wake_evt), .load_val(stab_reload),
    .count_en(state == PS_WAIT), .done(stab_done)
  );

  stop_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_accept(stop_accept), .wake(wake),
    .wake_cls(wake_cls), .stab_done(stab_done), .state(state),
    .wake_evt(wake_evt), .resume(resume), .take_irq(take_irq),
    .hold_pending(hold_pending)
  );

  assign cpu_clk_en = (state == PS_RUN);
  assign osc_stop   = (state == PS_STOP);
  assign in_stop    = (state == PS_STOP);
  assign in_wait    = (state == PS_WAIT);
endmodule

// File: rtl/stop_power_chk.sv
module stop_power_chk #(
  parameter int N_EXT = 7,
  parameter int N_PER = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic [N_EXT-1:0] ext_irq,
  input logic [N_EXT-1:0] ext_mask,
  input logic [N_PER-1:0] per_irq,
  input logic [N_PER-1:0] per_mask,
  input logic             cpu_clk_en,
  input logic             osc_stop,
  input logic             in_stop,
  input logic             in_wait,
  input logic             stop_flag,
  input logic             resume,
  input logic             take_irq,
  input logic             hold_pending
);
  logic any_wake;
  assign any_wake = nmi_req | (|(ext_irq & ~ext_mask)) | (|(per_irq & ~per_mask));

  // R2
  stop_gates_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (!cpu_clk_en && osc_stop && stop_flag));

  // R4
  masked_stays_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !any_wake) |=> in_stop);

  // R5
  wake_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && any_wake) |=> (in_wait && !osc_stop && !cpu_clk_en));

  // R11
  flag_clear_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !stop_flag);

  // R12
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // R12
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume ? $countones({take_irq, hold_pending}) == 1
           : (!take_irq && !hold_pending));

  // R6
  resume_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume) |-> ($past(in_wait) && cpu_clk_en));
endmodule

bind stop_power_ctrl stop_power_chk #(.N_EXT(N_EXT), .N_PER(N_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .ext_irq(ext_irq),
  .ext_mask(ext_mask), .per_irq(per_irq), .per_mask(per_mask),
  .cpu_clk_en(cpu_clk_en), .osc_stop(osc_stop), .in_stop(in_stop),
  .in_wait(in_wait), .stop_flag(stop_flag), .resume(resume),
  .take_irq(take_irq), .hold_pending(hold_pending)
);

// File: tb/test_stop_power_ctrl.sv
module test_stop_power_ctrl;
  localparam int DATA_W = 8;
  localparam int N_EXT  = 7;
  localparam int N_PER  = 4;
  localparam int PW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic nmi_req = 1'b0;
  logic [N_EXT-1:0] ext_irq = '0, ext_mask = '1;
  logic [N_PER-1:0] per_irq = '0, per_mask = '1;
  logic in_service = 1'b0, int_en = 1'b0;
  logic [PW-1:0] svc_prio = '0, irq_prio = '0;
  logic cpu_clk_en, osc_stop, in_stop, in_wait, stop_flag, resume, take_irq, hold_pending;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  stop_power_ctrl i_stop_power_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .nmi_req(nmi_req), .ext_irq(ext_irq),
    .ext_mask(ext_mask), .per_irq(per_irq), .per_mask(per_mask),
    .in_service(in_service), .svc_prio(svc_prio), .irq_prio(irq_prio),
    .int_en(int_en), .cpu_clk_en(cpu_clk_en), .osc_stop(osc_stop),
    .in_stop(in_stop), .in_wait(in_wait), .stop_flag(stop_flag),
    .resume(resume), .take_irq(take_irq), .hold_pending(hold_pending)
  );

  function automatic logic exp_take(input logic nmi, input logic svc_on,
                                    input logic [PW-1:0] sp, input logic [PW-1:0] ip,
                                    input logic ie);
    if (nmi) return 1'b1;
    if (!ie) return 1'b0;
    if (!svc_on) return 1'b1;
    return (ip < sp);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // packed view of the run-state outputs: clk_en,osc,stop,wait,flag,resume
  function automatic logic [7:0] st();
    return {2'b0, cpu_clk_en, osc_stop, in_stop, in_wait, stop_flag, resume};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enter_stop();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    check("R2 entered", st(), 8'b0001_1010);
  endtask

  // kind: 0 nmi, 1 external, 2 peripheral, 3 nmi plus external
  task automatic wake_case(input int kind, input int n, input logic svc_on,
                           input logic [PW-1:0] sp, input logic [PW-1:0] ip,
                           input logic ie, input bit try_masked);
    logic et;
    wr(2'd2, 8'(n));
    enter_stop();
    in_service = svc_on; svc_prio = sp; irq_prio = ip; int_en = ie;
    ext_mask = '1; per_mask = '1;
    if (try_masked) begin
      ext_irq = 7'h7F; per_irq = 4'hF;
      repeat (3) @(negedge clk);
      check("R4 masked lines ignored", st(), 8'b0001_1010);
      ext_irq = '0; per_irq = '0;
    end
    case (kind)
      0: nmi_req = 1'b1;
      1: begin ext_mask = 7'h7F & ~(7'h01 << (n % N_EXT)); ext_irq = 7'h7F; end
      2: begin per_mask = 4'hE; per_irq = 4'h1; end
      default: begin nmi_req = 1'b1; ext_mask = 7'h00; ext_irq = 7'h01; end
    endcase
    et = exp_take(kind == 0 || kind == 3, svc_on, sp, ip, ie);
    @(posedge clk); @(negedge clk);
    nmi_req = 1'b0; ext_irq = '0; per_irq = '0;
    check("R5 wait entered", st(), 8'b0000_0100);
    check("R11 flag cleared", {7'b0, stop_flag}, 8'h00);
    for (int i = 1; i <= n + 1; i++) begin
      @(posedge clk); @(negedge clk);
      if (i < n + 1) begin
        if (in_wait !== 1'b1 || resume !== 1'b0) check("R6 still waiting", st(), 8'b0000_0100);
      end else begin
        check("R6 resume cycle", st(), 8'b0010_0001);
        if (kind == 0 || kind == 3) check("R7 nmi class", {6'b0, take_irq, hold_pending}, {6'b0, et, ~et});
        else if (svc_on && !(ip < sp)) check("R8 pending class", {6'b0, take_irq, hold_pending}, {6'b0, et, ~et});
        else check("R9 enable class", {6'b0, take_irq, hold_pending}, {6'b0, et, ~et});
      end
    end
    @(posedge clk); @(negedge clk);
    check("R12 pulse single", {5'b0, resume, take_irq, hold_pending}, 8'h00);
    repeat (2) @(negedge clk);
    check("R11 stays running", st(), 8'b0010_0000);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {st()[7:0] | {5'b0, take_irq, hold_pending, 1'b0}}, 8'b0010_0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reload reset value: shows as 17 cycles of wait
    enter_stop();
    nmi_req = 1'b1;
    @(posedge clk); @(negedge clk);
    nmi_req = 1'b0;
    repeat (16) @(negedge clk);
    check("R1 default reload not done", {7'b0, in_wait}, 8'h01);
    @(negedge clk);
    check("R1 default reload done", {7'b0, resume}, 8'h01);
    // R3
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    check("R3 no mode select", st(), 8'b0010_0000);
    // directed corner cases
    wake_case(0, 0, 1'b1, 3'd0, 3'd0, 1'b0, 1'b1);
    wake_case(1, 1, 1'b1, 3'd3, 3'd3, 1'b1, 1'b0);
    wake_case(1, 2, 1'b1, 3'd3, 3'd2, 1'b1, 1'b0);
    wake_case(2, 3, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0);
    wake_case(3, 5, 1'b1, 3'd1, 3'd6, 1'b0, 1'b0);
    wake_case(2, 40, 1'b0, 3'd5, 3'd4, 1'b1, 1'b1);
    // R10 reset during stop
    enter_stop();
    #3 rst_n = 1'b0;
    #1 check("R10 reset in stop", st(), 8'b0010_0000);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    // R10 reset during wait
    wr(2'd2, 8'd6);
    enter_stop();
    nmi_req = 1'b1; @(posedge clk); @(negedge clk); nmi_req = 1'b0;
    #3 rst_n = 1'b0;
    #1 check("R10 reset in wait", st(), 8'b0010_0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (resume !== 1'b0) check("R10 no stale resume", {7'b0, resume}, 8'h00);
    end
    check("R10 no stale resume", {5'b0, resume, take_irq, hold_pending}, 8'h00);
    // constrained random
    for (int k = 0; k < 40; k++) begin
      wake_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 20)),
                1'($urandom_range(0, 1)), PW'($urandom_range(0, 7)),
                PW'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)));
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end
endmodule